// File: doc/BRIEF.md
# CSR Access Fault Arbiter

This block decides, for one control-and-status-register access at a time, whether the access completes or traps. If it traps, the block also says which trap: illegal instruction or virtual instruction. It models a hart that has the hypervisor extension. The request carries the 12-bit register address, a write flag, the current privilege level, and the virtualization flag. Alongside it come the two 64-bit state-enable words (machine level and hypervisor level) and the three indirect-select values (machine, supervisor, virtual supervisor).

The decision has two ordered stages. The first stage looks only at the addressed register: whether it is implemented, whether a write hits a read-only register, whether the current mode may reach the register's level, and whether the state-enable bits gate the indirect-access family. Within this stage, any illegal-instruction cause outranks any virtual-instruction cause. The second stage runs only when the first stage raises nothing. It checks the select value that an indirect data register would use, and a reserved value makes the access illegal. So a virtual-instruction fault from a hypervisor-level enable bit that is clear is never overridden by a reserved virtual-supervisor select value.

The verdict is registered. It appears as a one-hot word one clock after the request.

Top module: `csrx_fault_arb`

## Requirements
- R1: One clock after an edge with `req_vld`=1, `rsp_vld` is 1 and `rsp_oh` is one-hot, with bit 0 = no fault, bit 1 = illegal instruction, bit 2 = virtual instruction. One clock after an edge with `req_vld`=0, both `rsp_vld` and `rsp_oh` are 0.
- R2: Only these addresses are implemented: 0x100, 0x150, 0x151, 0x250, 0x251, 0x300, 0x350, 0x351, 0x600, 0xC00, 0xF14. Any other address gives illegal.
- R3: Read-only registers are those with address bits [11:10] = 2'b11. A write (`req_wr`=1) to one of them gives illegal; a read does not.
- R4: Privilege levels are encoded as `priv_lvl` 3 = M, 1 = S, 0 = U, and 2 is treated as U. `virt_on` is ignored in M. The register's level is address bits [9:8]. M reaches every level. HS reaches levels 0 to 2. U reaches level 0 only, and anything else gives illegal. VS: level 3 gives illegal and level 2 gives virtual. VU: level 3 gives illegal, and levels 1 and 2 give virtual.
- R5: In the first stage, an illegal cause beats a virtual cause. Example: a VS read of 0x250 with the machine-level enable bit clear gives illegal.
- R6: If bit 60 of `m_gate` is 0, any access from a mode other than M to 0x150, 0x151, 0x250 or 0x251 gives illegal.
- R7: If bit 60 of `m_gate` is 1 and bit 60 of `h_gate` is 0, a VS or VU access to 0x150 or 0x151 gives virtual. HS ignores `h_gate`, and M ignores both enable words.
- R8: If the first stage is clean, an access to data register 0x151, 0x251 or 0x351 whose select value lies outside 0x030..0x0FF gives illegal. Accesses to the select registers themselves never check a select value.
- R9: The select value used by 0x351 is `mi_sel`. For 0x151 it is `si_sel` when not virtualized and `vsi_sel` in VS. For 0x251 it is `vsi_sel`.
- R10: The second stage is skipped when the first stage faults. A VS access to 0x151 with the machine bit set, the hypervisor bit clear and a reserved `vsi_sel` gives virtual.
- R11: While `rst_n` is low, and for the first clock after it rises, `rsp_vld` and `rsp_oh` stay 0 even with `req_vld`=1. Assertion of the reset is asynchronous and its release is synchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_wr | input | 1 | Access writes the register |
| priv_lvl | input | 2 | Current privilege level |
| virt_on | input | 1 | Hart is virtualized |
| m_gate | input | 64 | Machine-level state-enable word |
| h_gate | input | 64 | Hypervisor-level state-enable word |
| mi_sel | input | SEL_W | Machine indirect select value |
| si_sel | input | SEL_W | Supervisor indirect select value |
| vsi_sel | input | SEL_W | Virtual supervisor indirect select value |
| rsp_vld | output | 1 | Verdict present |
| rsp_oh | output | 3 | One-hot verdict: none, illegal, virtual |

## Verification
The central corner is a VS access to the supervisor indirect data register with the hypervisor enable clear and a reserved select value. A design with one flat priority level would report illegal there, not virtual.

The bench also sweeps every mode against both enable bits and both select classes on every indirect register. This catches a design that gates HS with the hypervisor bit, or that gates M at all. It also targets a VS data access that reads the non-virtual select, and a first stage that lets a virtual cause hide an illegal one.

Read-only writes, unimplemented addresses, and outputs held quiet during and just after reset are each checked directly. Each has its own wrong result: a missed trap, or a spurious verdict.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  localparam logic [11:0] A_SSTAT  = 12'h100;
  localparam logic [11:0] A_SISEL  = 12'h150;
  localparam logic [11:0] A_SIREG  = 12'h151;
  localparam logic [11:0] A_VSISEL = 12'h250;
  localparam logic [11:0] A_VSIREG = 12'h251;
  localparam logic [11:0] A_MSTAT  = 12'h300;
  localparam logic [11:0] A_MISEL  = 12'h350;
  localparam logic [11:0] A_MIREG  = 12'h351;
  localparam logic [11:0] A_HSTAT  = 12'h600;
  localparam logic [11:0] A_CYC    = 12'hC00;
  localparam logic [11:0] A_HARTID = 12'hF14;

  localparam logic [2:0] RES_NONE = 3'b001;
  localparam logic [2:0] RES_ILL  = 3'b010;
  localparam logic [2:0] RES_VIRT = 3'b100;

  typedef enum logic [1:0] {SRC_NONE, SRC_M, SRC_S, SRC_VS} sel_src_e;

  typedef struct packed {
    logic       hit;
    logic       ro;
    logic [1:0] lvl;
    logic       ind;
    logic       s_grp;
    sel_src_e   src;
  } csr_attr_t;

  typedef struct packed {
    logic ill;
    logic virt;
  } fault_t;
endpackage

// File: rtl/csrx_addr_decode.sv
module csrx_addr_decode
  import csrx_pkg::*;
(
  input  logic [11:0] addr,
  output csr_attr_t   attr
);
  always_comb begin
    attr.ro    = (addr[11:10] == 2'b11);
    attr.lvl   = addr[9:8];
    attr.hit   = 1'b0;
    attr.ind   = 1'b0;
    attr.s_grp = 1'b0;
    attr.src   = SRC_NONE;
    case (addr)
      A_SSTAT, A_MSTAT, A_HSTAT, A_CYC, A_HARTID, A_MISEL: attr.hit = 1'b1;
      A_SISEL: begin
        attr.hit = 1'b1; attr.ind = 1'b1; attr.s_grp = 1'b1;
      end
      A_SIREG: begin
        attr.hit = 1'b1; attr.ind = 1'b1; attr.s_grp = 1'b1; attr.src = SRC_S;
      end
      A_VSISEL: begin
        attr.hit = 1'b1; attr.ind = 1'b1;
      end
      A_VSIREG: begin
        attr.hit = 1'b1; attr.ind = 1'b1; attr.src = SRC_VS;
      end
      A_MIREG: begin
        attr.hit = 1'b1; attr.src = SRC_M;
      end
      default: attr.hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/csrx_direct_stage.sv
module csrx_direct_stage
  import csrx_pkg::*;
(
  input  csr_attr_t attr,
  input  logic      wr,
  input  logic      is_m,
  input  logic      is_s,
  input  logic      is_v,
  input  logic      m_bit,
  input  logic      h_bit,
  output fault_t    flt
);
  logic priv_ill, priv_virt, gate_ill, gate_virt;

  always_comb begin
    priv_ill  = 1'b0;
    priv_virt = 1'b0;
    if (!is_m) begin
      if (!is_v) begin
        priv_ill = is_s ? (attr.lvl == 2'd3) : (attr.lvl != 2'd0);
      end else begin
        priv_ill  = (attr.lvl == 2'd3);
        priv_virt = is_s ? (attr.lvl == 2'd2)
                         : (attr.lvl == 2'd1 || attr.lvl == 2'd2);
      end
    end
  end

  assign gate_ill  = !is_m && attr.ind && !m_bit;
  assign gate_virt = is_v && attr.s_grp && !h_bit;

  assign flt.ill  = !attr.hit || (wr && attr.ro) || priv_ill || gate_ill;
  assign flt.virt = priv_virt || gate_virt;
endmodule

// File: rtl/csrx_indirect_stage.sv
module csrx_indirect_stage
  import csrx_pkg::*;
#(
  parameter int SEL_W  = 12,
  parameter int SEL_LO = 'h030,
  parameter int SEL_HI = 'h0FF
) (
  input  sel_src_e           src,
  input  logic               is_v,
  input  logic [SEL_W-1:0]   mi_sel,
  input  logic [SEL_W-1:0]   si_sel,
  input  logic [SEL_W-1:0]   vsi_sel,
  output logic               rsv_ill
);
  localparam logic [SEL_W-1:0] LO = SEL_W'(SEL_LO);
  localparam logic [SEL_W-1:0] HI = SEL_W'(SEL_HI);

  logic [SEL_W-1:0] pick;

  always_comb begin
    case (src)
      SRC_M:   pick = mi_sel;
      SRC_S:   pick = is_v ? vsi_sel : si_sel;
      SRC_VS:  pick = vsi_sel;
      default: pick = LO;
    endcase
  end

  assign rsv_ill = (src != SRC_NONE) && ((pick < LO) || (pick > HI));
endmodule

// File: rtl/csrx_fault_arb.sv
module csrx_fault_arb
  import csrx_pkg::*;
#(
  parameter int SEL_W      = 12,
  parameter int SEL_LO     = 'h030,
  parameter int SEL_HI     = 'h0FF,
  parameter int CSRIND_BIT = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [11:0]        req_addr,
  input  logic               req_wr,
  input  logic [1:0]         priv_lvl,
  input  logic               virt_on,
  input  logic [63:0]        m_gate,
  input  logic [63:0]        h_gate,
  input  logic [SEL_W-1:0]   mi_sel,
  input  logic [SEL_W-1:0]   si_sel,
  input  logic [SEL_W-1:0]   vsi_sel,
  output logic               rsp_vld,
  output logic [2:0]         rsp_oh
);
  logic      rst_meta_n, rst_sync_n;
  logic      is_m, is_s, is_v;
  csr_attr_t attr;
  fault_t    flt1;
  logic      rsv_ill;
  logic [2:0] oh_d;
  logic      vld_d;
  logic      unused_gate_bits;

  assign unused_gate_bits = ^{m_gate, h_gate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign is_m = (priv_lvl == 2'd3);
  assign is_s = (priv_lvl == 2'd1);
  assign is_v = !is_m && virt_on;

  csrx_addr_decode u_dec (
    .addr (req_addr),
    .attr (attr)
  );

  csrx_direct_stage u_st1 (
    .attr  (attr),
    .wr    (req_wr),
    .is_m  (is_m),
    .is_s  (is_s),
    .is_v  (is_v),
    .m_bit (m_gate[CSRIND_BIT]),
    .h_bit (h_gate[CSRIND_BIT]),
    .flt   (flt1)
  );

  csrx_indirect_stage #(
    .SEL_W  (SEL_W),
    .SEL_LO (SEL_LO),
    .SEL_HI (SEL_HI)
  ) u_st2 (
    .src     (attr.src),
    .is_v    (is_v),
    .mi_sel  (mi_sel),
    .si_sel  (si_sel),
    .vsi_sel (vsi_sel),
    .rsv_ill (rsv_ill)
  );

  always_comb begin
    vld_d = req_vld;
    oh_d  = 3'b000;
    if (req_vld) begin
      if (flt1.ill)       oh_d = RES_ILL;
      else if (flt1.virt) oh_d = RES_VIRT;
      else if (rsv_ill)   oh_d = RES_ILL;
      else                oh_d = RES_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_vld <= 1'b0;
      rsp_oh  <= 3'b000;
    end else begin
      rsp_vld <= vld_d;
      rsp_oh  <= oh_d;
    end
  end
endmodule

// File: rtl/csrx_fault_chk.sv
module csrx_fault_chk
  import csrx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [11:0] req_addr,
  input logic        req_wr,
  input logic [1:0]  priv_lvl,
  input logic        virt_on,
  input logic        m_bit,
  input logic        h_bit,
  input logic        rsp_vld,
  input logic [2:0]  rsp_oh
);
  logic ind_addr, s_addr;
  assign ind_addr = (req_addr == A_SISEL) || (req_addr == A_SIREG) ||
                    (req_addr == A_VSISEL) || (req_addr == A_VSIREG);
  assign s_addr   = (req_addr == A_SISEL) || (req_addr == A_SIREG);

  // R1
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> ($countones(rsp_oh) == 1));
  // R1
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (rsp_oh == 3'b000));
  // R3
  a_r3_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr && req_addr[11:10] == 2'b11) |=> (rsp_oh == RES_ILL));
  // R4
  a_r4_m_no_virtual: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_lvl == 2'd3) |=> !rsp_oh[2]);
  // R6
  a_r6_mgate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_lvl != 2'd3 && !m_bit && ind_addr) |=> (rsp_oh == RES_ILL));
  // R7, R10
  a_r7_hgate_virtual: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_lvl != 2'd3 && virt_on && m_bit && !h_bit && s_addr)
      |=> (rsp_oh == RES_VIRT));
endmodule

bind csrx_fault_arb csrx_fault_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_vld  (req_vld),
  .req_addr (req_addr),
  .req_wr   (req_wr),
  .priv_lvl (priv_lvl),
  .virt_on  (virt_on),
  .m_bit    (m_gate[CSRIND_BIT]),
  .h_bit    (h_gate[CSRIND_BIT]),
  .rsp_vld  (rsp_vld),
  .rsp_oh   (rsp_oh)
);

// File: tb/sim_csrx_fault_arb.sv
module sim_csrx_fault_arb;
  logic        clk, rst_n, req_vld, req_wr, virt_on, rsp_vld;
  logic [11:0] req_addr, mi_sel, si_sel, vsi_sel;
  logic [1:0]  priv_lvl;
  logic [63:0] m_gate, h_gate;
  logic [2:0]  rsp_oh;
  int n_run, n_fail;
  bit done;

  localparam logic [2:0] E_OK = 3'b001, E_IL = 3'b010, E_VI = 3'b100;
  localparam logic [11:0] SV = 12'h040, SR = 12'h010;

  csrx_fault_arb u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, wr, priv, virt, mbit, hbit, expected}
  localparam logic [20:0] TBL [16] = '{
    {12'h300, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, E_OK},
    {12'h300, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, E_IL},
    {12'h100, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, E_IL},
    {12'h100, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, E_OK},
    {12'h100, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, E_VI},
    {12'h600, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, E_VI},
    {12'h600, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, E_OK},
    {12'hC00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, E_IL},
    {12'hC00, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, E_OK},
    {12'hF14, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, E_OK},
    {12'hF14, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, E_IL},
    {12'h123, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, E_IL},
    {12'h250, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, E_IL},
    {12'h151, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, E_IL},
    {12'h600, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, E_VI},
    {12'h151, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, E_VI}
  };

  function automatic logic [2:0] ref_verdict(input logic [11:0] a, input logic w,
      input logic [1:0] p, input logic v, input logic mb, input logic hb,
      input logic [11:0] ms, input logic [11:0] ss, input logic [11:0] vs);
    logic m, s, vv, known, indr, ill, vir;
    logic [1:0] lv;
    logic [11:0] pick;
    logic has_pick;
    m = (p == 2'd3); s = (p == 2'd1); vv = !m && v; lv = a[9:8];
    known = (a inside {12'h100, 12'h150, 12'h151, 12'h250, 12'h251, 12'h300,
                       12'h350, 12'h351, 12'h600, 12'hC00, 12'hF14});
    indr = (a inside {12'h150, 12'h151, 12'h250, 12'h251});
    ill = !known || (w && a[11:10] == 2'b11);
    vir = 1'b0;
    if (!m && !vv && s && lv == 2'd3) ill = 1'b1;
    if (!m && !vv && !s && lv != 2'd0) ill = 1'b1;
    if (vv && lv == 2'd3) ill = 1'b1;
    if (vv && s && lv == 2'd2) vir = 1'b1;
    if (vv && !s && (lv == 2'd1 || lv == 2'd2)) vir = 1'b1;
    if (!m && indr && !mb) ill = 1'b1;
    if (vv && (a == 12'h150 || a == 12'h151) && !hb) vir = 1'b1;
    if (ill) return E_IL;
    if (vir) return E_VI;
    has_pick = 1'b1; pick = 12'h0;
    if (a == 12'h351) pick = ms;
    else if (a == 12'h151) pick = vv ? vs : ss;
    else if (a == 12'h251) pick = vs;
    else has_pick = 1'b0;
    if (has_pick && (pick < 12'h030 || pick > 12'h0FF)) return E_IL;
    return E_OK;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual vld/oh=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input logic [11:0] a, input logic w, input logic [1:0] p,
      input logic v, input logic mb, input logic hb, input logic [11:0] ms,
      input logic [11:0] ss, input logic [11:0] vs, input logic [2:0] exp,
      input string tag);
    @(negedge clk);
    req_addr = a; req_wr = w; priv_lvl = p; virt_on = v;
    m_gate = '0; m_gate[60] = mb; h_gate = '0; h_gate[60] = hb;
    mi_sel = ms; si_sel = ss; vsi_sel = vs; req_vld = 1'b1;
    @(negedge clk);
    check(tag, {rsp_vld, rsp_oh}, {1'b1, exp});
    req_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_vld = 1'b1; req_addr = 12'h300; req_wr = 1'b0;
    priv_lvl = 2'd3; virt_on = 1'b0; m_gate = '1; h_gate = '1;
    mi_sel = SV; si_sel = SV; vsi_sel = SV;
    repeat (3) @(negedge clk);
    check("R11 in reset", {rsp_vld, rsp_oh}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first clock after release", {rsp_vld, rsp_oh}, 4'b0000);
    req_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle", {rsp_vld, rsp_oh}, 4'b0000);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < 16; i++) begin
      run(TBL[i][20:9], TBL[i][8], TBL[i][7:6], TBL[i][5], TBL[i][4], TBL[i][3],
          SV, SV, SV, TBL[i][2:0], $sformatf("R2/R3/R4/R5/R7 row %0d", i));
    end

    // sweep: R6 R7 R8 R10 over modes, enable bits, select class
    for (int md = 0; md < 5; md++)
      for (int g = 0; g < 4; g++)
        for (int rs = 0; rs < 2; rs++)
          for (int ai = 0; ai < 5; ai++) begin
            logic [1:0] p; logic v; logic [11:0] a, sl;
            case (md)
              0: begin p = 2'd3; v = 1'b0; end
              1: begin p = 2'd1; v = 1'b0; end
              2: begin p = 2'd0; v = 1'b0; end
              3: begin p = 2'd1; v = 1'b1; end
              default: begin p = 2'd0; v = 1'b1; end
            endcase
            case (ai)
              0: a = 12'h150; 1: a = 12'h151; 2: a = 12'h250;
              3: a = 12'h251; default: a = 12'h351;
            endcase
            sl = rs[0] ? SR : SV;
            run(a, 1'b0, p, v, g[1], g[0], sl, sl, sl,
                ref_verdict(a, 1'b0, p, v, g[1], g[0], sl, sl, sl),
                $sformatf("R6/R7/R8/R10 md%0d g%0d rs%0d a%h", md, g, rs, a));
          end

    run(12'h151, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, SV, SV, SR, E_VI, "R10 VS sireg reserved vsel");
    run(12'h151, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, SV, SR, SV, E_OK, "R9 VS sireg uses vsi_sel");
    run(12'h151, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, SV, SV, SR, E_OK, "R9 HS sireg uses si_sel");
    run(12'h251, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, SV, SV, SR, E_IL, "R9 HS vsireg uses vsi_sel");
    run(12'h351, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, SR, SV, SV, E_IL, "R8 mireg reserved");
    run(12'h351, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 12'h0FF, SR, SR, E_OK, "R8 mireg upper bound");
    run(12'h151, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, SV, 12'h030, SR, E_OK, "R7 M ignores gates");
    run(12'h150, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, SV, SR, SR, E_OK, "R8 select reg no check");
    run(12'h100, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, SV, SV, SV, E_IL, "R4 priv 2 as U");
    run(12'hC00, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, SV, SV, SV, E_OK, "R3 read of read-only");
    @(negedge clk);
    check("R1 idle after request", {rsp_vld, rsp_oh}, 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule